// File: doc/BRIEF.md
# Configuration Window Access Decoder

This block sits between a host memory port and a configuration fabric. A control port programs a window (base address, power-of-two size, enable). Every host access whose address falls inside the window is turned into a configuration request. The block subtracts the base from the host address and splits the result into bus, device, function and register offset. It then issues the request on a downstream port and waits for a response that says whether the targeted function exists.

Host accesses outside the window are not answered. They are flagged on a separate miss output so that other address decoders can claim them. Reads that reach a missing function complete with all-ones data in the byte lanes covered by the access size. Writes that reach a missing function complete with no other effect.

Top module: `cfgwin_decoder`

## Requirements
- R1: After reset no window is mapped, `h_ready` is 1, and every host access is answered on `h_miss`.
- R2: An access is claimed only when base <= `h_addr` <= base+size-1. An unclaimed access gives a one-cycle `h_miss` pulse in the cycle after it is accepted, and it issues no downstream request.
- R3: For a claimed access, offset = `h_addr` - base. The request carries the following fields:
  - `d_bus` = offset[28:20]
  - `d_dev` = offset[19:15]
  - `d_fn` = offset[14:12]
  - `d_reg` = offset[11:0]
- R4: Size codes on `h_size` are 0 = 1 byte, 1 = 2 bytes and 2 = 4 bytes. Code 3 is treated as 4 bytes, so `d_size` never shows 3.
- R5: A read to an absent function (`d_rsp_present`=0) returns 0x000000FF, 0x0000FFFF or 0xFFFFFFFF for 1-, 2- or 4-byte accesses.
- R6: A read to a present function returns the low 1, 2 or 4 bytes of `d_rsp_rdata`, with the upper bytes zero.
- R7: A write is forwarded with `d_write`=1 and `d_wdata`. Its host response has `r_rdata`=0 whether or not the function is present, so a write to an absent function is dropped silently.
- R8: An update with the enable set is rejected when the size is not a power of two, is below 2^20 or is above 2^28. A rejected update leaves the previous mapping in force.
- R9: An update with the enable clear unmaps the window. An accepted update replaces base and size, and the old range is no longer claimed.
- R10: `h_ready` is low from acceptance of a claimed access until its response. Only one request is outstanding at a time, and `r_valid` is a one-cycle pulse.
- R11: Bus bits at positions equal to or above log2(size) read as zero. For example, a 2^20 window always gives bus 0, and a 2^21 window gives bus 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_upd | input | 1 | Window update strobe |
| ctl_en | input | 1 | Map the window on update |
| ctl_base | input | 32 | Window base address |
| ctl_size | input | 32 | Window size in bytes |
| h_valid | input | 1 | Host access valid |
| h_ready | output | 1 | Host access accepted when high |
| h_addr | input | 32 | Host address |
| h_write | input | 1 | 1 = write |
| h_size | input | 2 | Access size code |
| h_wdata | input | 32 | Write data |
| h_miss | output | 1 | Pulse: access outside window |
| r_valid | output | 1 | Pulse: response to claimed access |
| r_rdata | output | 32 | Response data |
| d_valid | output | 1 | Downstream request valid |
| d_ready | input | 1 | Downstream request accepted |
| d_write | output | 1 | Request is a write |
| d_bus | output | 9 | Bus number |
| d_dev | output | 5 | Device number |
| d_fn | output | 3 | Function number |
| d_reg | output | 12 | Register offset |
| d_size | output | 2 | Normalised size code |
| d_wdata | output | 32 | Write data |
| d_rsp_valid | input | 1 | Downstream response valid |
| d_rsp_present | input | 1 | Targeted function exists |
| d_rsp_rdata | input | 32 | Read data from function |

## Verification
The hardest case to reach from the ports is a rejected window update. It leaves no trace of its own, so the bench first maps a known window. It then sends illegal updates: a size that is not a power of two, one below the lower bound and one above the upper bound. After these, an access to the old window must still be claimed and an access to the proposed base must still miss. The exact last byte of a full-size window, and the bytes one below and one above the window, are also exercised. These cover the range compare and the field split at their extreme values.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;
    localparam int DATA_W  = 32;
    localparam int BUS_W   = 9;
    localparam int DEV_W   = 5;
    localparam int FN_W    = 3;
    localparam int REG_W   = 12;
    localparam int FN_LSB  = REG_W;
    localparam int DEV_LSB = FN_LSB + FN_W;
    localparam int BUS_LSB = DEV_LSB + DEV_W;
    localparam int FIELD_W = BUS_LSB + BUS_W;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [BUS_W-1:0] bus;
        logic [DEV_W-1:0] dev;
        logic [FN_W-1:0]  fn;
        logic [REG_W-1:0] reg_off;
    } cfg_target_t;

    function automatic acc_size_e norm_size(input logic [1:0] code);
        return (code == 2'd3) ? SZ_WORD : acc_size_e'(code);
    endfunction

    function automatic logic [DATA_W-1:0] lane_mask(input acc_size_e s);
        logic [DATA_W-1:0] m;
        case (s)
            SZ_BYTE: m = DATA_W'(32'h0000_00FF);
            SZ_HALF: m = DATA_W'(32'h0000_FFFF);
            default: m = '1;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/cfgwin_map.sv
module cfgwin_map
    import cfgwin_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int MIN_LOG2 = 20,
    parameter int MAX_LOG2 = 28,
    localparam int LG_W    = $clog2(ADDR_W) + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               upd,
    input  logic               en,
    input  logic [ADDR_W-1:0]  base,
    input  logic [ADDR_W-1:0]  size,
    input  logic [ADDR_W-1:0]  addr,
    output logic               hit,
    output logic [FIELD_W-1:0] offset,
    output logic [LG_W-1:0]    win_lg
);
    localparam logic [ADDR_W-1:0] SIZE_MIN = ADDR_W'(1) << MIN_LOG2;
    localparam logic [ADDR_W-1:0] SIZE_MAX = ADDR_W'(1) << MAX_LOG2;

    logic              mapped_q;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] size_q;
    logic [LG_W-1:0]   lg_q;
    logic [LG_W-1:0]   lg_new;
    logic              size_ok;
    logic [ADDR_W-1:0] full_off;

    assign size_ok = (size != '0) && ((size & (size - ADDR_W'(1))) == '0)
                     && (size >= SIZE_MIN) && (size <= SIZE_MAX);

    always_comb begin
        lg_new = '0;
        for (int i = 0; i < ADDR_W; i++) begin
            if (size[i]) lg_new = LG_W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mapped_q <= 1'b0;
            base_q   <= '0;
            size_q   <= '0;
            lg_q     <= '0;
        end else if (upd) begin
            if (!en) begin
                mapped_q <= 1'b0;
            end else if (size_ok) begin
                mapped_q <= 1'b1;
                base_q   <= base;
                size_q   <= size;
                lg_q     <= lg_new;
            end
        end
    end

    assign full_off = addr - base_q;
    assign hit      = mapped_q && (full_off < size_q);
    assign offset   = full_off[FIELD_W-1:0];
    assign win_lg   = lg_q;
endmodule

// File: rtl/cfgwin_split.sv
module cfgwin_split
    import cfgwin_pkg::*;
#(
    parameter int LG_W = 6
) (
    input  logic [FIELD_W-1:0] offset,
    input  logic [LG_W-1:0]    win_lg,
    output cfg_target_t        tgt
);
    logic [BUS_W-1:0] bus_keep;

    generate
        for (genvar i = 0; i < BUS_W; i++) begin : g_bus_mask
            assign bus_keep[i] = (BUS_LSB + i) < int'(win_lg);
        end
    endgenerate

    assign tgt.bus     = offset[BUS_LSB +: BUS_W] & bus_keep;
    assign tgt.dev     = offset[DEV_LSB +: DEV_W];
    assign tgt.fn      = offset[FN_LSB +: FN_W];
    assign tgt.reg_off = offset[REG_W-1:0];
endmodule

// File: rtl/cfgwin_fill.sv
module cfgwin_fill
    import cfgwin_pkg::*;
(
    input  logic              is_write,
    input  logic              present,
    input  acc_size_e         size,
    input  logic [DATA_W-1:0] dn_rdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mask;

    assign mask = lane_mask(size);

    always_comb begin
        if (is_write)      rdata = '0;
        else if (!present) rdata = mask;
        else               rdata = dn_rdata & mask;
    end
endmodule

// File: rtl/cfgwin_decoder.sv
module cfgwin_decoder
    import cfgwin_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int MIN_LOG2 = 20,
    parameter int MAX_LOG2 = 28
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_upd,
    input  logic              ctl_en,
    input  logic [ADDR_W-1:0] ctl_base,
    input  logic [ADDR_W-1:0] ctl_size,
    input  logic              h_valid,
    output logic              h_ready,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic              h_write,
    input  logic [1:0]        h_size,
    input  logic [DATA_W-1:0] h_wdata,
    output logic              h_miss,
    output logic              r_valid,
    output logic [DATA_W-1:0] r_rdata,
    output logic              d_valid,
    input  logic              d_ready,
    output logic              d_write,
    output logic [BUS_W-1:0]  d_bus,
    output logic [DEV_W-1:0]  d_dev,
    output logic [FN_W-1:0]   d_fn,
    output logic [REG_W-1:0]  d_reg,
    output logic [1:0]        d_size,
    output logic [DATA_W-1:0] d_wdata,
    input  logic              d_rsp_valid,
    input  logic              d_rsp_present,
    input  logic [DATA_W-1:0] d_rsp_rdata
);
    localparam int LG_W = $clog2(ADDR_W) + 1;

    logic               win_hit;
    logic [FIELD_W-1:0] win_off;
    logic [LG_W-1:0]    win_lg;
    cfg_target_t        tgt_dec;
    logic [DATA_W-1:0]  fill_data;

    seq_state_e         state_q;
    cfg_target_t        tgt_q;
    logic               write_q;
    acc_size_e          size_q;
    logic [DATA_W-1:0]  wdata_q;
    logic               rvalid_q;
    logic [DATA_W-1:0]  rdata_q;
    logic               miss_q;

    cfgwin_map #(
        .ADDR_W  (ADDR_W),
        .MIN_LOG2(MIN_LOG2),
        .MAX_LOG2(MAX_LOG2)
    ) u_map (
        .clk   (clk),
        .rst   (rst),
        .upd   (ctl_upd),
        .en    (ctl_en),
        .base  (ctl_base),
        .size  (ctl_size),
        .addr  (h_addr),
        .hit   (win_hit),
        .offset(win_off),
        .win_lg(win_lg)
    );

    cfgwin_split #(.LG_W(LG_W)) u_split (
        .offset(win_off),
        .win_lg(win_lg),
        .tgt   (tgt_dec)
    );

    cfgwin_fill u_fill (
        .is_write(write_q),
        .present (d_rsp_present),
        .size    (size_q),
        .dn_rdata(d_rsp_rdata),
        .rdata   (fill_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            tgt_q    <= '0;
            write_q  <= 1'b0;
            size_q   <= SZ_WORD;
            wdata_q  <= '0;
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
            miss_q   <= 1'b0;
        end else begin
            rvalid_q <= 1'b0;
            miss_q   <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (h_valid) begin
                        if (win_hit) begin
                            tgt_q   <= tgt_dec;
                            write_q <= h_write;
                            size_q  <= norm_size(h_size);
                            wdata_q <= h_wdata;
                            state_q <= ST_ISSUE;
                        end else begin
                            miss_q  <= 1'b1;
                        end
                    end
                end
                ST_ISSUE: begin
                    if (d_ready) state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (d_rsp_valid) begin
                        rvalid_q <= 1'b1;
                        rdata_q  <= fill_data;
                        state_q  <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign h_ready = (state_q == ST_IDLE);
    assign h_miss  = miss_q;
    assign r_valid = rvalid_q;
    assign r_rdata = rdata_q;
    assign d_valid = (state_q == ST_ISSUE);
    assign d_write = write_q;
    assign d_bus   = tgt_q.bus;
    assign d_dev   = tgt_q.dev;
    assign d_fn    = tgt_q.fn;
    assign d_reg   = tgt_q.reg_off;
    assign d_size  = size_q;
    assign d_wdata = wdata_q;
endmodule

// File: rtl/cfgwin_decoder_chk.sv
module cfgwin_decoder_chk
    import cfgwin_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             h_ready,
    input logic             h_miss,
    input logic             r_valid,
    input logic             d_valid,
    input logic             d_ready,
    input logic [BUS_W-1:0] d_bus,
    input logic [DEV_W-1:0] d_dev,
    input logic [FN_W-1:0]  d_fn,
    input logic [REG_W-1:0] d_reg,
    input logic [1:0]       d_size
);
    a_r1_idle_after_reset: assert property (@(posedge clk)
        $fell(rst) |-> h_ready && !d_valid && !r_valid);

    a_r2_miss_no_req: assert property (@(posedge clk) disable iff (rst)
        h_miss |-> !d_valid && !r_valid);

    a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        d_valid |-> !h_ready);

    a_r10_rsp_pulse: assert property (@(posedge clk) disable iff (rst)
        r_valid |=> !r_valid);

    a_r3_req_hold: assert property (@(posedge clk) disable iff (rst)
        d_valid && !d_ready |=> d_valid && $stable(d_bus) && $stable(d_dev)
                                && $stable(d_fn) && $stable(d_reg));

    a_r4_size_norm: assert property (@(posedge clk) disable iff (rst)
        d_valid |-> d_size != 2'd3);
endmodule

bind cfgwin_decoder cfgwin_decoder_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .h_ready(h_ready),
    .h_miss (h_miss),
    .r_valid(r_valid),
    .d_valid(d_valid),
    .d_ready(d_ready),
    .d_bus  (d_bus),
    .d_dev  (d_dev),
    .d_fn   (d_fn),
    .d_reg  (d_reg),
    .d_size (d_size)
);

// File: tb/cfgwin_decoder_tb.sv
module cfgwin_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_upd = 1'b0, ctl_en = 1'b0;
    logic [31:0] ctl_base = '0, ctl_size = '0;
    logic        h_valid = 1'b0, h_write = 1'b0;
    logic [31:0] h_addr = '0, h_wdata = '0;
    logic [1:0]  h_size = '0;
    logic        h_ready, h_miss, r_valid;
    logic [31:0] r_rdata;
    logic        d_valid, d_write;
    logic        d_ready = 1'b1;
    logic [8:0]  d_bus;
    logic [4:0]  d_dev;
    logic [2:0]  d_fn;
    logic [11:0] d_reg;
    logic [1:0]  d_size;
    logic [31:0] d_wdata;
    logic        d_rsp_valid = 1'b0, d_rsp_present = 1'b0;
    logic [31:0] d_rsp_rdata = '0;

    int total = 0;
    int bad   = 0;

    bit          o_miss, o_dv, o_rv, o_ready, o_wr;
    logic [8:0]  o_bus;
    logic [4:0]  o_dev;
    logic [2:0]  o_fn;
    logic [11:0] o_reg;
    logic [1:0]  o_size;
    logic [31:0] o_wdata, o_rdata;

    always #10 clk = ~clk;

    cfgwin_decoder dut_i (
        .clk(clk), .rst(rst),
        .ctl_upd(ctl_upd), .ctl_en(ctl_en), .ctl_base(ctl_base), .ctl_size(ctl_size),
        .h_valid(h_valid), .h_ready(h_ready), .h_addr(h_addr), .h_write(h_write),
        .h_size(h_size), .h_wdata(h_wdata), .h_miss(h_miss),
        .r_valid(r_valid), .r_rdata(r_rdata),
        .d_valid(d_valid), .d_ready(d_ready), .d_write(d_write),
        .d_bus(d_bus), .d_dev(d_dev), .d_fn(d_fn), .d_reg(d_reg),
        .d_size(d_size), .d_wdata(d_wdata),
        .d_rsp_valid(d_rsp_valid), .d_rsp_present(d_rsp_present),
        .d_rsp_rdata(d_rsp_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic win_update(input bit en, input logic [31:0] base,
                              input logic [31:0] size);
        @(negedge clk);
        ctl_upd = 1'b1; ctl_en = en; ctl_base = base; ctl_size = size;
        @(negedge clk);
        ctl_upd = 1'b0;
    endtask

    task automatic access(input logic [31:0] a, input bit wr, input logic [1:0] sz,
                          input logic [31:0] wd, input bit pres,
                          input logic [31:0] dn);
        @(negedge clk);
        h_valid = 1'b1; h_addr = a; h_write = wr; h_size = sz; h_wdata = wd;
        @(negedge clk);
        h_valid = 1'b0;
        o_miss = h_miss; o_dv = d_valid; o_ready = h_ready; o_wr = d_write;
        o_bus = d_bus; o_dev = d_dev; o_fn = d_fn; o_reg = d_reg;
        o_size = d_size; o_wdata = d_wdata;
        o_rv = 1'b0; o_rdata = '0;
        if (o_dv) begin
            @(negedge clk);
            d_rsp_valid = 1'b1; d_rsp_present = pres; d_rsp_rdata = dn;
            @(negedge clk);
            d_rsp_valid = 1'b0;
            o_rv = r_valid; o_rdata = r_rdata;
        end
    endtask

    task automatic expect_miss(input logic [31:0] a, input string tag);
        access(a, 1'b0, 2'd2, '0, 1'b1, '0);
        chk(o_miss && !o_dv, tag, {30'd0, o_miss, o_dv}, 32'h2);
    endtask

    task automatic expect_read(input logic [31:0] a, input logic [1:0] sz,
                               input bit pres, input logic [31:0] dn,
                               input logic [8:0] eb, input logic [4:0] ed,
                               input logic [2:0] ef, input logic [11:0] er,
                               input logic [31:0] erd, input string tag);
        access(a, 1'b0, sz, '0, pres, dn);
        chk(o_dv && !o_miss && !o_ready, {tag, " claim"}, {29'd0, o_dv, o_miss, o_ready}, 32'h4);
        chk({o_bus, o_dev, o_fn, o_reg} == {eb, ed, ef, er}, {tag, " fields R3"},
            {3'd0, o_bus, o_dev, o_fn, o_reg}, {3'd0, eb, ed, ef, er});
        chk(o_rv && o_rdata == erd, {tag, " data"}, o_rdata, erd);
    endtask

    task automatic t_reset;
        chk(h_ready && !d_valid && !r_valid, "R1 reset outputs",
            {29'd0, h_ready, d_valid, r_valid}, 32'h4);
        expect_miss(32'h0000_0000, "R1 unmapped miss");
        expect_miss(32'h8000_0000, "R1 unmapped miss high");
    endtask

    task automatic t_present_reads;
        win_update(1'b1, 32'h8000_0000, 32'h1000_0000);
        expect_read(32'h8032_A1A4, 2'd2, 1'b1, 32'hDEAD_BEEF, 9'd3, 5'd5, 3'd2,
                    12'h1A4, 32'hDEAD_BEEF, "R6 word read");
        expect_read(32'h8032_A1A4, 2'd0, 1'b1, 32'hAABB_CCDD, 9'd3, 5'd5, 3'd2,
                    12'h1A4, 32'h0000_00DD, "R6 byte read");
        expect_read(32'h8032_A1A4, 2'd1, 1'b1, 32'hAABB_CCDD, 9'd3, 5'd5, 3'd2,
                    12'h1A4, 32'h0000_CCDD, "R6 half read");
    endtask

    task automatic t_absent_reads;
        expect_read(32'h8000_0000, 2'd0, 1'b0, 32'h1234_5678, 9'd0, 5'd0, 3'd0,
                    12'h000, 32'h0000_00FF, "R5 byte fill");
        expect_read(32'h8000_0000, 2'd1, 1'b0, 32'h1234_5678, 9'd0, 5'd0, 3'd0,
                    12'h000, 32'h0000_FFFF, "R5 half fill");
        expect_read(32'h8000_0000, 2'd2, 1'b0, 32'h1234_5678, 9'd0, 5'd0, 3'd0,
                    12'h000, 32'hFFFF_FFFF, "R5 word fill");
        expect_read(32'h8000_0004, 2'd3, 1'b0, 32'h0, 9'd0, 5'd0, 3'd0,
                    12'h004, 32'hFFFF_FFFF, "R4 code3 fill");
        chk(o_size == 2'd2, "R4 code3 normalised", {30'd0, o_size}, 32'd2);
    endtask

    task automatic t_bounds;
        expect_miss(32'h7FFF_FFFF, "R2 below base");
        expect_miss(32'h9000_0000, "R2 past end");
        expect_read(32'h8FFF_FFFF, 2'd0, 1'b1, 32'h0000_0042, 9'h0FF, 5'h1F, 3'h7,
                    12'hFFF, 32'h0000_0042, "R2 last byte");
    endtask

    task automatic t_write;
        access(32'h8000_0010, 1'b1, 2'd1, 32'h0000_1234, 1'b0, 32'hFFFF_FFFF);
        chk(o_dv && o_wr && o_wdata == 32'h1234 && o_size == 2'd1, "R7 write fwd",
            o_wdata, 32'h1234);
        chk(o_rv && o_rdata == 32'h0, "R7 absent write ack", o_rdata, 32'h0);
    endtask

    task automatic t_reject;
        win_update(1'b1, 32'h4000_0000, 32'h0030_0000);
        win_update(1'b1, 32'h4000_0000, 32'h0008_0000);
        win_update(1'b1, 32'h4000_0000, 32'h2000_0000);
        expect_miss(32'h4000_0000, "R8 rejected base not claimed");
        expect_read(32'h8032_A1A4, 2'd2, 1'b1, 32'h0BAD_F00D, 9'd3, 5'd5, 3'd2,
                    12'h1A4, 32'h0BAD_F00D, "R8 old window kept");
    endtask

    task automatic t_remap;
        win_update(1'b1, 32'h4000_0000, 32'h0010_0000);
        expect_miss(32'h8000_0000, "R9 old range dropped");
        expect_miss(32'h4010_0000, "R9 new end");
        expect_read(32'h400F_F123, 2'd2, 1'b1, 32'h1111_2222, 9'd0, 5'h1F, 3'h7,
                    12'h123, 32'h1111_2222, "R11 1M window bus zero");
        win_update(1'b1, 32'h4000_0000, 32'h0020_0000);
        expect_read(32'h401F_F000, 2'd2, 1'b0, 32'h0, 9'd1, 5'h1F, 3'h7,
                    12'h000, 32'hFFFF_FFFF, "R11 2M window bus one");
        win_update(1'b0, 32'h4000_0000, 32'h0020_0000);
        expect_miss(32'h4000_0000, "R9 disable unmaps");
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_present_reads();
        t_absent_reads();
        t_bounds();
        t_write();
        t_reject();
        t_remap();
        chk(r_valid == 1'b0, "R10 pulse ends", {31'd0, r_valid}, 32'h0);
        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule